// File: doc/BRIEF.md
# Two-Dimensional Variable-Factor Despreader

This block correlates an equalized multicarrier stream against a ±1 chip sequence in two directions at once. Samples arrive serially, one subcarrier per valid cycle, `NSC` subcarriers per symbol. A data symbol is spread over `SFf = 2^sff_log2` neighbouring subcarriers and over `SFt = 2^sft_log2` consecutive symbols. For each frequency block of a time group, the block returns one signed correlation value.

Each group of `LANES` consecutive samples is gathered into a parallel word. A tree of pairwise add units then reduces the word. Multiplexers set how many tree levels combine pairs, `sff_log2` of them, so the word yields `LANES/SFf` frequency partial sums. A last-stage adder in each lane adds that partial sum to the running value held in a small per-lane bank. The bank has `NSC/LANES` words and carries the sum across the symbols of the group. After the final symbol of the group, the finished lane values are copied into an output register. From there they stream out one per cycle.

A group controller tracks where the input stream stands. It waits in `G_WAIT` for the first sample of a group. On that sample it latches the configuration and moves to `G_SOLO` when `SFt = 1`, or to `G_OPEN` when `SFt > 1`. At the end of a symbol, `G_OPEN` goes to `G_CLOSE` when `SFt = 2` and to `G_MID` otherwise. `G_MID` repeats until the next symbol is the last one and then goes to `G_CLOSE`. `G_CLOSE` and `G_SOLO` return to `G_WAIT` at the end of their symbol. The output side has two states: `O_IDLE`, and `O_DRAIN`, which is entered on each final-symbol chunk and left after `LANES/SFf` outputs.

Top module: `desp_net`

## Requirements
- R1: While `rst_n` is low, and after its release until results are due, `out_valid` is 0, and the controller waits for the first sample of a new group.
- R2: `in_code` = 1 means chip −1 and 0 means chip +1. `in_data` is a two's-complement sample of `DW` bits. Samples of one symbol arrive in increasing subcarrier order, `NSC` per symbol, and symbols follow back to back.
- R3: `sff_log2` and `sft_log2` are taken on the first valid sample of a group. Changes to them during the rest of the group have no effect on that group's results.
- R4: The result for frequency block f of a group is the sum, over symbols n < SFt of the group and j < SFf, of chip × sample for subcarrier f·SFf+j.
- R5: Each group yields exactly `NSC/SFf` results, in increasing f.
- R6: For every `LANES`-sample chunk of a group's final symbol, `LANES/SFf` results come out on consecutive cycles. The first is visible after the second rising edge following the cycle that carries the chunk's last sample.
- R7: `out_valid` is 0 in every cycle not covered by R6, including all cycles spent in non-final symbols.
- R8: A cycle with `in_valid` low changes no counter and no stored value, whatever `in_code` and `in_data` carry.
- R9: Outputs are `DW+log2(LANES)+1` bits wide. Full-scale samples over all `LANES` chips give +2^(DW−1)·LANES and −2^(DW−1)·LANES without wrapping.
- R10: With SFf = SFt = 1, each result equals its sample with the sign of its chip applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample present this cycle |
| in_code | input | 1 | Chip bit, 1 = −1, 0 = +1 |
| in_data | input | DW | Signed equalized sample |
| sff_log2 | input | $clog2(log2(LANES)+1) | log2 of the frequency spreading factor |
| sft_log2 | input | $clog2(log2(LANES)+1) | log2 of the time spreading factor |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | DW+log2(LANES)+1 | Signed despread result |

## Verification
Each kind of internal fault shows at the ports in its own way. A subcarrier counter that slips by one misaligns the parallel word, and the next result of a final symbol is wrong. A group state that is entered wrongly moves the whole burst of results by a symbol. The bench then sees `out_valid` a symbol's length early or late. A fault in a lane bank, or in the forcing of the first-symbol feedback, stays hidden until the final symbol of a group. It then shows up only in that lane's values, once per chunk. The reference model predicts `out_valid` and `out_data` for every cycle, so the first cycle that goes wrong is reported.

// File: rtl/desp_pkg.sv
package desp_pkg;

    // Progress through one time group of symbols.
    typedef enum logic [2:0] {
        G_WAIT,
        G_OPEN,
        G_MID,
        G_CLOSE,
        G_SOLO
    } grp_state_t;

    // Output streaming.
    typedef enum logic {
        O_IDLE,
        O_DRAIN
    } out_state_t;

endpackage

// File: rtl/desp_add_unit.sv
// Pairwise signed chip combiner: the pair (co, dout) stands for
// c1*d1 + c2*d2, with the sign carried in co.
module desp_add_unit #(
    parameter int W = 17
) (
    input  logic         c1,
    input  logic [W-1:0] d1,
    input  logic         c2,
    input  logic [W-1:0] d2,
    output logic         co,
    output logic [W-1:0] dout
);
    always_comb begin
        co   = c2;
        dout = (c1 ^ c2) ? (d2 - d1) : (d2 + d1);
    end
endmodule

// File: rtl/desp_tree.sv
// Reconfigurable reduction tree: levels 1..lvl_sel pair up neighbours,
// the remaining levels pass their inputs straight through.
module desp_tree #(
    parameter int LANES = 16,
    parameter int W     = 17,
    localparam int LOGL = $clog2(LANES),
    localparam int SELW = $clog2(LOGL + 1)
) (
    input  logic [SELW-1:0]           lvl_sel,
    input  logic [LANES-1:0]          in_c,
    input  logic [LANES-1:0][W-1:0]   in_d,
    output logic [LANES-1:0]          out_c,
    output logic [LANES-1:0][W-1:0]   out_d
);
    logic [LOGL:0][LANES-1:0]        lc;
    logic [LOGL:0][LANES-1:0][W-1:0] ld;

    assign lc[0] = in_c;
    assign ld[0] = in_d;

    for (genvar s = 1; s <= LOGL; s++) begin : g_lvl
        localparam logic [SELW-1:0] LV = SELW'(s);
        logic on;
        assign on = (LV <= lvl_sel);
        for (genvar m = 0; m < LANES; m++) begin : g_slot
            if (m < (LANES >> s)) begin : g_pair
                logic         ac;
                logic [W-1:0] ad;
                desp_add_unit #(.W(W)) u_au (
                    .c1  (lc[s-1][2*m]),
                    .d1  (ld[s-1][2*m]),
                    .c2  (lc[s-1][2*m+1]),
                    .d2  (ld[s-1][2*m+1]),
                    .co  (ac),
                    .dout(ad)
                );
                assign lc[s][m] = on ? ac : lc[s-1][m];
                assign ld[s][m] = on ? ad : ld[s-1][m];
            end else begin : g_pass
                assign lc[s][m] = on ? 1'b0 : lc[s-1][m];
                assign ld[s][m] = on ? '0   : ld[s-1][m];
            end
        end
    end

    assign out_c = lc[LOGL];
    assign out_d = ld[LOGL];
endmodule

// File: rtl/desp_ctrl.sv
// Group controller: subcarrier and symbol counting, configuration capture,
// and chunk tagging for the datapath.
module desp_ctrl
    import desp_pkg::*;
#(
    parameter int LANES = 16,
    parameter int NSC   = 64,
    localparam int LOGL = $clog2(LANES),
    localparam int SELW = $clog2(LOGL + 1),
    localparam int SCW  = $clog2(NSC),
    localparam int QW   = SCW - LOGL,
    localparam int CW   = LOGL + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [SELW-1:0] sff_in,
    input  logic [SELW-1:0] sft_in,
    output logic [LOGL-1:0] slot,
    output logic            chunk_done,
    output logic [QW-1:0]   chunk_q,
    output logic            chunk_first,
    output logic            chunk_last,
    output logic [SELW-1:0] cfg_sff
);
    grp_state_t      state, nstate;
    logic [SCW-1:0]  sc_cnt;
    logic [CW-1:0]   sym_cnt;
    logic [CW-1:0]   span;
    logic [SELW-1:0] cfg_sft;
    logic            sym_end;

    assign sym_end = in_valid && (sc_cnt == SCW'(NSC - 1));
    assign span    = CW'(1) << cfg_sft;

    always_comb begin
        nstate = state;
        unique case (state)
            G_WAIT:  if (in_valid) nstate = (sft_in == '0) ? G_SOLO : G_OPEN;
            G_OPEN:  if (sym_end)  nstate = (span == CW'(2)) ? G_CLOSE : G_MID;
            G_MID:   if (sym_end && (sym_cnt == span - CW'(2))) nstate = G_CLOSE;
            G_CLOSE: if (sym_end)  nstate = G_WAIT;
            G_SOLO:  if (sym_end)  nstate = G_WAIT;
            default: nstate = G_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= G_WAIT;
        else        state <= nstate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sc_cnt  <= '0;
            sym_cnt <= '0;
            cfg_sff <= '0;
            cfg_sft <= '0;
        end else begin
            if (in_valid) sc_cnt <= sym_end ? '0 : sc_cnt + 1'b1;
            if (nstate == G_WAIT) sym_cnt <= '0;
            else if (sym_end)     sym_cnt <= sym_cnt + 1'b1;
            if (state == G_WAIT && in_valid) begin
                cfg_sff <= sff_in;
                cfg_sft <= sft_in;
            end
        end
    end

    always_comb begin
        slot        = sc_cnt[LOGL-1:0];
        chunk_q     = sc_cnt[SCW-1:LOGL];
        chunk_done  = in_valid && (sc_cnt[LOGL-1:0] == '1);
        chunk_first = 1'b0;
        chunk_last  = 1'b0;
        unique case (state)
            G_OPEN:  chunk_first = 1'b1;
            G_SOLO:  begin chunk_first = 1'b1; chunk_last = 1'b1; end
            G_CLOSE: chunk_last = 1'b1;
            default: ;
        endcase
    end

    // R3
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != G_WAIT && $past(state) != G_WAIT) |-> ($stable(cfg_sff) && $stable(cfg_sft)));

    // R5
    grp_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == G_CLOSE || state == G_SOLO) && sym_end) |=> (state == G_WAIT));

    // R8
    gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(sc_cnt) && $stable(sym_cnt)));
endmodule

// File: rtl/desp_net.sv
// Two-dimensional despreader: serial gather, reconfigurable add tree,
// per-lane time accumulation banks, serial result stream.
module desp_net
    import desp_pkg::*;
#(
    parameter int LANES = 16,
    parameter int NSC   = 64,
    parameter int DW    = 12,
    localparam int LOGL  = $clog2(LANES),
    localparam int SELW  = $clog2(LOGL + 1),
    localparam int OW    = DW + LOGL + 1,
    localparam int DEPTH = NSC / LANES,
    localparam int QW    = $clog2(NSC) - LOGL,
    localparam int CW    = LOGL + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_code,
    input  logic signed [DW-1:0] in_data,
    input  logic [SELW-1:0]      sff_log2,
    input  logic [SELW-1:0]      sft_log2,
    output logic                 out_valid,
    output logic signed [OW-1:0] out_data
);
    logic [LOGL-1:0] slot;
    logic            chunk_done, chunk_first, chunk_last;
    logic [QW-1:0]   chunk_q;
    logic [SELW-1:0] cfg_sff;

    desp_ctrl #(.LANES(LANES), .NSC(NSC)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .sff_in     (sff_log2),
        .sft_in     (sft_log2),
        .slot       (slot),
        .chunk_done (chunk_done),
        .chunk_q    (chunk_q),
        .chunk_first(chunk_first),
        .chunk_last (chunk_last),
        .cfg_sff    (cfg_sff)
    );

    // Serial-to-parallel gather and once-per-chunk add-unit input registers.
    logic [LANES-1:0]          sp_c, par_c;
    logic [LANES-1:0][DW-1:0]  sp_d;
    logic [LANES-1:0][OW-1:0]  par_d;
    logic                      p_go, p_first, p_last;
    logic [QW-1:0]             p_q;
    logic [SELW-1:0]           p_l;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_c <= '0; sp_d <= '0; par_c <= '0; par_d <= '0;
            p_go <= 1'b0; p_first <= 1'b0; p_last <= 1'b0; p_q <= '0; p_l <= '0;
        end else begin
            p_go <= chunk_done;
            if (in_valid) begin
                sp_c[slot] <= in_code;
                sp_d[slot] <= in_data;
            end
            if (chunk_done) begin
                for (int i = 0; i < LANES - 1; i++) begin
                    par_c[i] <= sp_c[i];
                    par_d[i] <= OW'($signed(sp_d[i]));
                end
                par_c[LANES-1] <= in_code;
                par_d[LANES-1] <= OW'(in_data);
                p_q     <= chunk_q;
                p_first <= chunk_first;
                p_last  <= chunk_last;
                p_l     <= cfg_sff;
            end
        end
    end

    logic [LANES-1:0]         t_c;
    logic [LANES-1:0][OW-1:0] t_d;

    desp_tree #(.LANES(LANES), .W(OW)) u_tree (
        .lvl_sel(p_l),
        .in_c   (par_c),
        .in_d   (par_d),
        .out_c  (t_c),
        .out_d  (t_d)
    );

    // Last stage: signed partial sum plus bank feedback, per lane.
    logic [LANES-1:0][OW-1:0] acc;
    logic [LANES-1:0]         lane_on;

    for (genvar m = 0; m < LANES; m++) begin : g_lane
        logic [OW-1:0]        bank [DEPTH];
        logic signed [OW-1:0] tval, prev, sum;
        always_comb begin
            tval = t_c[m] ? -$signed(t_d[m]) : $signed(t_d[m]);
            prev = p_first ? '0 : $signed(bank[p_q]);
            sum  = tval + prev;
        end
        assign acc[m]     = sum;
        assign lane_on[m] = (m < (LANES >> p_l));
        always_ff @(posedge clk) begin
            if (p_go && lane_on[m]) bank[p_q] <= sum;
        end
    end

    // Parallel-to-serial output stage.
    out_state_t               ostate;
    logic [LANES-1:0][OW-1:0] ps;
    logic [LOGL-1:0]          o_idx;
    logic [CW-1:0]            o_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ostate <= O_IDLE;
            ps     <= '0;
            o_idx  <= '0;
            o_cnt  <= '0;
        end else if (p_go && p_last) begin
            ostate <= O_DRAIN;
            ps     <= acc;
            o_idx  <= '0;
            o_cnt  <= CW'(LANES >> p_l);
        end else begin
            unique case (ostate)
                O_IDLE:  ;
                O_DRAIN: begin
                    if ({1'b0, o_idx} == o_cnt - 1'b1) ostate <= O_IDLE;
                    else                               o_idx  <= o_idx + 1'b1;
                end
                default: ostate <= O_IDLE;
            endcase
        end
    end

    always_comb begin
        out_valid = 1'b0;
        out_data  = '0;
        unique case (ostate)
            O_IDLE:  ;
            O_DRAIN: begin
                out_valid = 1'b1;
                out_data  = $signed(ps[o_idx]);
            end
            default: ;
        endcase
    end

    // R6
    last_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_go && p_last) |=> out_valid);

    // R7
    no_early_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(p_go && p_last));
endmodule

// File: tb/test_desp_net.sv
module test_desp_net;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 16;
    localparam int NSC   = 64;
    localparam int DW    = 12;
    localparam int OW    = DW + 5;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic                 in_code = 1'b0;
    logic signed [DW-1:0] in_data = '0;
    logic [2:0]           sff_log2 = '0;
    logic [2:0]           sft_log2 = '0;
    logic                 out_valid;
    logic signed [OW-1:0] out_data;

    desp_net #(.LANES(LANES), .NSC(NSC), .DW(DW)) i_desp_net (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
        .in_data(in_data), .sff_log2(sff_log2), .sft_log2(sft_log2),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad   = 0;
    int ecnt  = 0;
    bit run   = 1'b0;
    int    due_q[$];
    int    val_q[$];
    string tag_q[$];
    int gd [16][NSC];
    bit gc [16][NSC];

    always @(posedge clk) ecnt <= ecnt + 1;

    // Per-cycle comparison against the behavioural model.
    always @(negedge clk) begin
        if (run) begin
            bit exp_v;
            exp_v = (due_q.size() > 0) && (due_q[0] == ecnt);
            if (exp_v || out_valid) begin
                total++;
                if (out_valid !== exp_v) begin
                    bad++;
                    $display("FAIL %s out_valid at cycle %0d: got %0b expected %0b",
                             exp_v ? "R6" : "R7", ecnt, out_valid, exp_v);
                end else if (int'(out_data) != val_q[0]) begin
                    bad++;
                    $display("FAIL %s out_data at cycle %0d: got %0d expected %0d",
                             tag_q[0], ecnt, out_data, val_q[0]);
                end
                if (exp_v) begin
                    void'(due_q.pop_front());
                    void'(val_q.pop_front());
                    void'(tag_q.pop_front());
                end
            end
        end
    end

    task automatic send_group(input int fl, input int tl, input int pat,
                              input bit gaps, input bit twiddle, input string tag);
        int sff = 1 << fl;
        int sft = 1 << tl;
        int per = LANES >> fl;
        for (int n = 0; n < sft; n++) begin
            for (int sc = 0; sc < NSC; sc++) begin
                int d;
                bit c;
                if (gaps && (sc % 5 == 2)) begin
                    @(negedge clk);
                    in_valid = 1'b0;
                    in_code  = 1'b1;
                    in_data  = 12'sh7A5;   // R8: ignored while in_valid is low
                end
                @(negedge clk);
                case (pat)
                    1: begin c = 1'b1; d = -2048; end
                    2: begin c = 1'b0; d = -2048; end
                    3: begin c = sc[0]; d = sc * 37 - 1000; end
                    4: begin c = (sc % 3 == 0); d = int'($urandom_range(4095)) - 2048; end
                    default: begin c = 1'($urandom_range(1)); d = int'($urandom_range(4095)) - 2048; end
                endcase
                in_valid = 1'b1;
                in_code  = c;
                in_data  = DW'(d);
                if (n == 0 && sc == 0) begin
                    sff_log2 = 3'(fl);
                    sft_log2 = 3'(tl);
                end else if (twiddle) begin
                    sff_log2 = 3'((fl + 1 + sc) % 5);   // R3: must not matter
                    sft_log2 = 3'((tl + 2 + sc) % 5);
                end
                gd[n][sc] = d;
                gc[n][sc] = c;
                if (n == sft - 1 && sc % LANES == LANES - 1) begin
                    int q = sc / LANES;
                    for (int m = 0; m < per; m++) begin
                        int f = q * per + m;
                        int s = 0;
                        for (int nn = 0; nn < sft; nn++)
                            for (int j = 0; j < sff; j++)
                                s += gc[nn][f*sff+j] ? -gd[nn][f*sff+j] : gd[nn][f*sff+j];
                        due_q.push_back(ecnt + 2 + m);
                        val_q.push_back(s);
                        tag_q.push_back(tag);
                    end
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        total++;
        if (out_valid !== 1'b0) begin
            bad++;
            $display("FAIL R1 out_valid in reset: got %0b expected 0", out_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        total++;
        if (out_valid !== 1'b0) begin
            bad++;
            $display("FAIL R1 out_valid after reset: got %0b expected 0", out_valid);
        end
        run = 1'b1;

        // R4 / R5: every legal factor pair with random chips and samples
        for (int fl = 0; fl <= 4; fl++)
            for (int tl = 0; tl <= 4 - fl; tl++)
                send_group(fl, tl, 0, 1'b0, 1'b0, "R4");
        send_group(0, 0, 3, 1'b0, 1'b0, "R10");
        send_group(4, 0, 1, 1'b0, 1'b0, "R9");
        send_group(2, 2, 2, 1'b0, 1'b0, "R9");
        send_group(2, 1, 0, 1'b1, 1'b0, "R8");
        send_group(1, 2, 0, 1'b0, 1'b1, "R3");
        send_group(3, 1, 4, 1'b0, 1'b0, "R2");
        send_group(0, 1, 0, 1'b1, 1'b1, "R5");

        repeat (40) @(negedge clk);
        total++;
        if (due_q.size() != 0) begin
            bad++;
            $display("FAIL R5 results missing: got %0d outstanding expected 0", due_q.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got hung run expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule